// File: doc/BRIEF.md
# Serial Command and Sampling Front End

This block is the host-facing control path of a multichannel converter. The host sends 16-bit frames, most significant bit first, over a serial link made of a serial clock, an active-low chip select and a data line. The block samples all three pins with a synchronizer on its own system clock. It takes a data bit on each rising serial-clock edge while chip select is low. It decodes the first four bits of a frame as a command.

A configuration-write frame stores its 12 data bits in a configuration register. The register drives the static reference controls, the sampling-length choice and the conversion-clock choice. A channel or test-input command opens a sampling window in the middle of the frame. The window lasts a set number of serial-clock rising edges, and it reports which input is selected. The block also produces the conversion clock. This clock comes from an oscillator input, from the raw serial clock, or from the serial clock divided by two or four.

Top module: `sfe_top`

## Requirements
- R1: After reset the configuration register and every field exported from it read zero, and the sample-enable output is low.
- R2: A frame whose command nibble (frame bits 15:12) is 0xA loads frame bits 11:0 into the configuration register once the 16th bit is taken. The exported fields are cfg bit 11 (internal reference select), bit 10 (2 V level select), bit 9 (long sampling) and bits 8:7 (conversion clock select).
- R3: If the serial clock pauses mid-frame while chip select stays low, the bit position and the partial word are kept, and the frame completes when clocking resumes.
- R4: Raising chip select before the 16th bit aborts the frame. The configuration register does not change, and the next frame starts again at bit 0.
- R5: Command codes 0x0 to 0x7 raise sample-enable once the fourth bit is taken. The block outputs the channel number equal to the code, with the test flag low.
- R6: Command codes 0xB, 0xC and 0xD raise sample-enable once the fourth bit is taken. The block outputs channel numbers 1, 2 and 3 with the test flag high.
- R7: Codes 0x8, 0x9, 0xA, 0xE and 0xF open no window. No code other than 0xA changes the configuration register.
- R8: Once opened, sample-enable stays high for exactly 12 further serial-clock rising edges when cfg bit 9 is 0, or 24 when it is 1. These edges are counted whether or not chip select is low.
- R9: The conversion clock follows the oscillator input for select 00 and the serial clock for 01. It is the serial clock divided by 4 for 10 and divided by 2 for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| sclk_i | input | 1 | Host serial clock |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| osc_i | input | 1 | Internal oscillator clock |
| sample_en_o | output | 1 | High while the sampling window is open |
| chan_o | output | 3 | Selected channel or test-input number |
| test_o | output | 1 | Selected input is a test input |
| ref_int_o | output | 1 | Internal reference selected |
| ref_2v_o | output | 1 | Internal reference level is 2 V |
| long_samp_o | output | 1 | Long sampling window selected |
| ck_sel_o | output | 2 | Conversion clock select |
| cfg_o | output | 12 | Full configuration register |
| conv_clk_o | output | 1 | Conversion clock |

## Verification
The bench sweeps all sixteen command codes. A decoder with an off-by-one range would open a window for 0x8 or 0xA, or would leave out 0xB or 0xD. A test-channel mapping that is off by one would also show here. The bench counts the window length to the edge in both settings. An off-by-one count makes sample-enable fall one edge early or late. A window gated by chip select would close at the end of the frame, which the long-window case exposes. A long pause mid-frame would catch a design that times out a partial word. An aborted frame followed by a channel command would catch a design that keeps its bit count across a chip-select deassertion. Edge counts on the conversion clock would reveal swapped divider encodings.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int CFG_W   = 12;

  typedef enum logic [1:0] {
    CK_OSC  = 2'b00,
    CK_SCLK = 2'b01,
    CK_DIV4 = 2'b10,
    CK_DIV2 = 2'b11
  } ck_sel_e;

  typedef struct packed {
    logic       ref_int;
    logic       ref_2v;
    logic       long_samp;
    ck_sel_e    ck_sel;
    logic [6:0] misc;
  } cfg_t;

  localparam logic [CMD_W-1:0] CMD_CFG    = 4'hA;
  localparam logic [CMD_W-1:0] CMD_TST_LO = 4'hB;
  localparam logic [CMD_W-1:0] CMD_TST_HI = 4'hD;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES*W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[(STAGES-1)*W-1:0], d_i};
  end

  assign q_o = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               cs_n_i,
  input  logic               sdi_i,
  output logic               cmd_stb_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic               frame_stb_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic               take;

  assign take        = bit_en_i && !cs_n_i;
  assign word_o      = {sh_q, sdi_i};
  assign cmd_o       = word_o[CMD_W-1:0];
  assign cmd_stb_o   = take && (cnt_q == CNT_W'(CMD_W-1));
  assign frame_stb_o = take && (cnt_q == CNT_W'(FRAME_W-1));

  // chip select high aborts; a paused clock simply holds state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_n_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (take) begin
      sh_q  <= word_o[FRAME_W-2:0];
      cnt_q <= (cnt_q == CNT_W'(FRAME_W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (cnt_q == '0)); // R4
  AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !bit_en_i) |=> $stable(cnt_q) && $stable(sh_q)); // R3
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int SHORT_WIN = 12,
  parameter int LONG_WIN  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               cmd_stb_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               frame_stb_i,
  input  logic [FRAME_W-1:0] word_i,
  output cfg_t               cfg_o,
  output logic               sample_en_o,
  output logic [2:0]         chan_o,
  output logic               test_o
);
  localparam int WIN_W = $clog2(LONG_WIN + 1);

  cfg_t             cfg_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [WIN_W-1:0] win_len;
  logic             is_chan, is_test;

  assign is_chan = !cmd_i[3];
  assign is_test = (cmd_i >= CMD_TST_LO) && (cmd_i <= CMD_TST_HI);
  assign win_len = cfg_q.long_samp ? WIN_W'(LONG_WIN) : WIN_W'(SHORT_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (frame_stb_i && word_i[FRAME_W-1 -: CMD_W] == CMD_CFG)
      cfg_q <= cfg_t'(word_i[CFG_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_en_o <= 1'b0;
      win_cnt_q   <= '0;
      chan_o      <= '0;
      test_o      <= 1'b0;
    end else if (!sample_en_o && cmd_stb_i && (is_chan || is_test)) begin
      sample_en_o <= 1'b1;
      win_cnt_q   <= '0;
      test_o      <= is_test;
      chan_o      <= is_test ? cmd_i[2:0] - 3'd2 : cmd_i[2:0];
    end else if (sample_en_o && sclk_rise_i) begin
      win_cnt_q <= win_cnt_q + 1'b1;
      if (win_cnt_q == win_len - 1'b1) sample_en_o <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;

  AST_WIN_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_en_o) |-> $past(cmd_stb_i)); // R5
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_o |-> (win_cnt_q < win_len)); // R8
  AST_CFG_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |-> $past(frame_stb_i)); // R2
endmodule

// File: rtl/sfe_convclk.sv
module sfe_convclk
  import sfe_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sclk_i,
  input  logic    sclk_rise_i,
  input  logic    osc_i,
  input  ck_sel_e sel_i,
  output logic    conv_clk_o
);
  logic [1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (sclk_rise_i) div_q <= div_q + 2'd1;
  end

  always_comb begin
    unique case (sel_i)
      CK_OSC:  conv_clk_o = osc_i;
      CK_SCLK: conv_clk_o = sclk_i;
      CK_DIV4: conv_clk_o = div_q[1];
      default: conv_clk_o = div_q[0];
    endcase
  end

  AST_DIV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_i |=> (div_q == $past(div_q) + 2'd1)); // R9
endmodule

// File: rtl/sfe_top.sv
module sfe_top
  import sfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_WIN   = 12,
  parameter int LONG_WIN    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             sdi_i,
  input  logic             osc_i,
  output logic             sample_en_o,
  output logic [2:0]       chan_o,
  output logic             test_o,
  output logic             ref_int_o,
  output logic             ref_2v_o,
  output logic             long_samp_o,
  output logic [1:0]       ck_sel_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             conv_clk_o
);
  logic               sclk_s, cs_s, sdi_s, sclk_d, sclk_rise;
  logic               cmd_stb, frame_stb;
  logic [CMD_W-1:0]   cmd;
  logic [FRAME_W-1:0] word;
  cfg_t               cfg;

  sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, sdi_i}),
    .q_o   ({sclk_s, cs_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_d;

  sfe_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (sclk_rise),
    .cs_n_i     (cs_s),
    .sdi_i      (sdi_s),
    .cmd_stb_o  (cmd_stb),
    .cmd_o      (cmd),
    .frame_stb_o(frame_stb),
    .word_o     (word)
  );

  sfe_ctrl #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .cmd_stb_i  (cmd_stb),
    .cmd_i      (cmd),
    .frame_stb_i(frame_stb),
    .word_i     (word),
    .cfg_o      (cfg),
    .sample_en_o(sample_en_o),
    .chan_o     (chan_o),
    .test_o     (test_o)
  );

  sfe_convclk u_ck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .sclk_rise_i(sclk_rise),
    .osc_i      (osc_i),
    .sel_i      (cfg.ck_sel),
    .conv_clk_o (conv_clk_o)
  );

  assign ref_int_o   = cfg.ref_int;
  assign ref_2v_o    = cfg.ref_2v;
  assign long_samp_o = cfg.long_samp;
  assign ck_sel_o    = cfg.ck_sel;
  assign cfg_o       = cfg;

  AST_CFG_STABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s)) |=> $stable(cfg)); // R4
endmodule

// File: tb/sfe_top_tb_top.sv
module sfe_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, osc = 1'b0;
  logic        sample_en, test, ref_int, ref_2v, long_samp, conv_clk;
  logic [2:0]  chan;
  logic [1:0]  ck_sel;
  logic [11:0] cfg;
  int n_chk = 0, n_fail = 0, ck_rises = 0;
  logic meas = 1'b0;

  always #4 clk = ~clk;

  sfe_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .osc_i(osc), .sample_en_o(sample_en), .chan_o(chan), .test_o(test),
    .ref_int_o(ref_int), .ref_2v_o(ref_2v), .long_samp_o(long_samp),
    .ck_sel_o(ck_sel), .cfg_o(cfg), .conv_clk_o(conv_clk)
  );

  always @(posedge conv_clk) if (meas) ck_rises++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; idle(4);
    sclk = 1'b0; idle(4);
  endtask

  task automatic send_bit(input bit b);
    sdi = b;
    pulse();
  endtask

  task automatic send_bits(input logic [15:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(v[i]);
  endtask

  task automatic begin_frame();
    cs_n = 1'b0; idle(4);
  endtask

  task automatic end_frame();
    cs_n = 1'b1; idle(6);
  endtask

  task automatic write_cfg(input logic [11:0] v);
    begin_frame(); send_bits({4'hA, v}, 15, 0); end_frame();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(cfg == 12'h0, "R1 cfg", cfg, 0);
    chk(sample_en == 1'b0, "R1 sample_en", sample_en, 0);

    // R2 load and field export
    write_cfg(12'hC80);
    chk(cfg == 12'hC80, "R2 cfg", cfg, 12'hC80);
    chk(ref_int == 1'b1 && ref_2v == 1'b1, "R2 ref fields", {ref_int, ref_2v}, 3);
    chk(long_samp == 1'b0 && ck_sel == 2'b01, "R2 samp/ck fields", {long_samp, ck_sel}, 1);
    write_cfg(12'h37F);
    chk(cfg == 12'h37F, "R2 cfg second", cfg, 12'h37F);
    chk(ref_int == 1'b0 && ref_2v == 1'b0 && long_samp == 1'b1 && ck_sel == 2'b10,
        "R2 fields second", {ref_int, ref_2v, long_samp, ck_sel}, 5'b00110);

    // short window, sweep every code
    write_cfg(12'h055);
    for (int c = 0; c < 16; c++) begin
      bit conv, is_t;
      int exp_ch;
      conv   = (c <= 7) || (c >= 11 && c <= 13);
      is_t   = (c >= 11);
      exp_ch = is_t ? c - 10 : c;
      begin_frame();
      send_bits({c[3:0], (c == 10) ? 12'h055 : 12'hFFF}, 15, 12);
      if (conv) begin
        chk(sample_en == 1'b1, is_t ? "R6 window open" : "R5 window open", sample_en, 1);
        chk(chan == exp_ch[2:0] && test == is_t,
            is_t ? "R6 test select" : "R5 channel select", {test, chan}, {is_t, exp_ch[2:0]});
      end else begin
        chk(sample_en == 1'b0, "R7 no window", sample_en, 0);
      end
      send_bits({c[3:0], (c == 10) ? 12'h055 : 12'hFFF}, 11, 1);
      chk(sample_en == conv, "R8 short window at 11 edges", sample_en, conv);
      send_bits({c[3:0], (c == 10) ? 12'h055 : 12'hFFF}, 0, 0);
      chk(sample_en == 1'b0, "R8 short window closed at 12", sample_en, 0);
      end_frame();
      chk(cfg == 12'h055, "R7 cfg untouched", cfg, 12'h055);
    end

    // R8 long window spans past the frame end
    write_cfg(12'h200);
    begin_frame();
    send_bits(16'h5000, 15, 12);
    chk(sample_en == 1'b1 && chan == 3'd5, "R8 long open", {sample_en, chan}, 4'hD);
    send_bits(16'h5000, 11, 0);
    end_frame();
    chk(sample_en == 1'b1, "R8 long still open after frame", sample_en, 1);
    repeat (11) pulse();
    chk(sample_en == 1'b1, "R8 long open at 23 edges", sample_en, 1);
    pulse();
    chk(sample_en == 1'b0, "R8 long closed at 24", sample_en, 0);

    // R3 pause mid-frame
    begin_frame();
    send_bits(16'hA9A6, 15, 8);
    idle(300);
    chk(cfg == 12'h200, "R3 cfg held during pause", cfg, 12'h200);
    send_bits(16'hA9A6, 7, 0);
    end_frame();
    chk(cfg == 12'h9A6, "R3 cfg after resume", cfg, 12'h9A6);

    // R4 abort then fresh frame
    begin_frame();
    send_bits(16'hA123, 15, 6);
    end_frame();
    chk(cfg == 12'h9A6, "R4 cfg unchanged after abort", cfg, 12'h9A6);
    begin_frame();
    send_bits(16'h3000, 15, 12);
    chk(sample_en == 1'b1 && chan == 3'd3, "R4 next frame restarts", {sample_en, chan}, 4'hB);
    send_bits(16'h3000, 11, 0);
    end_frame();
    chk(cfg == 12'h9A6, "R4 cfg after following frame", cfg, 12'h9A6);

    // R9 conversion clock
    write_cfg(12'h180);
    ck_rises = 0; meas = 1'b1; repeat (16) pulse(); meas = 1'b0;
    chk(ck_rises == 8, "R9 div2", ck_rises, 8);
    write_cfg(12'h100);
    ck_rises = 0; meas = 1'b1; repeat (16) pulse(); meas = 1'b0;
    chk(ck_rises == 4, "R9 div4", ck_rises, 4);
    write_cfg(12'h080);
    ck_rises = 0; meas = 1'b1; repeat (16) pulse(); meas = 1'b0;
    chk(ck_rises == 16, "R9 sclk", ck_rises, 16);
    write_cfg(12'h000);
    ck_rises = 0; meas = 1'b1;
    repeat (10) begin osc = 1'b1; idle(3); osc = 1'b0; idle(3); end
    meas = 1'b0;
    chk(ck_rises == 10, "R9 oscillator", ck_rises, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule